// File: doc/BRIEF.md
# Serial Audio Frame Timing Generator

This block produces the timing for a stereo serial audio link carrying two 16-bit words per frame in the usual I2S arrangement. As master it divides the system clock by a programmable 8-bit divisor to make the bit clock and word strobe. As slave it takes the bit clock and word strobe from outside through two-flop synchronizers. In both modes it shifts the left and right transmit words out MSB first and pulses an interrupt on the word-strobe edges or word starts chosen in its mode register.

Software writes four registers through a simple write port: the left word, the right word, the divisor and the mode. Writing the divisor or the mode restarts the frame from its beginning. A small controller with three states sequences each slot. ST_SYNC is the state after reset or restart, with the data line held at zero. On a word-strobe change (transition T_CHANGE) it moves to ST_ARMED. On the next bit-clock falling edge it takes transition T_LOAD to ST_SHIFT, which loads the slot's word. If the strobe changes again instead, transition T_REARM keeps it in ST_ARMED. In ST_SHIFT each following falling edge shifts one bit, and the next strobe change takes transition T_CHANGE back to ST_ARMED. A restart takes transition T_RESTART from any state to ST_SYNC.

Top module: `i2s_tmg_top`

## Requirements
- R1: After reset the mode register is 0, which selects slave mode. Then sck_o, ws_o, sd_o and irq_o are 0 and status_o is 2'b01. The divisor resets to DIV_RST.
- R2: In master mode (mode bit 0 = 1) the bit clock is high for DIV+1 cycles and low for DIV+1 cycles. After a write to the divisor (wr_sel=2) or to the mode (wr_sel=3), its first falling edge comes DIV+1 cycles after the write edge.
- R3: A master frame is 32 bit clocks, which is 64*(DIV+1) system clock cycles.
- R4: The word strobe changes only on a bit-clock falling edge. It is low for the left slot and high for the right slot, and it changes one bit clock before the slot's MSB. Data changes on falling edges, MSB first. The first falling edge after a restart drives the strobe low, and the next 16 falling edges carry the left word (wr_sel=0).
- R5: At the start of each slot the block loads the last value written to that channel (left wr_sel=0, right wr_sel=1). A word written in the middle of a slot is first sent in the next slot of that channel.
- R6: A write to the divisor or the mode restarts the frame. The bit clock goes high, the strobe goes high and the data line goes to 0, and the left word follows as R4 describes.
- R7: Mode bit 2 gates ws_o. When the bit is clear, ws_o stays 0 and status_o still tracks the internal strobe.
- R8: Mode bit 3 pulses irq_o for one cycle after each rising strobe edge.
- R9: Mode bit 4 pulses irq_o for one cycle after each falling strobe edge.
- R10: Mode bit 5 pulses irq_o for one cycle after each word MSB is loaded, which is twice per frame.
- R11: In slave mode (mode bit 0 = 0) the block shifts data on the synchronized falling edges of ext_sck and takes the strobe from ext_ws. sck_o and ws_o stay 0.
- R12: status_o[0] is the current strobe level and status_o[1] is high while the strobe selects the left channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 left, 1 right, 2 divisor, 3 mode |
| wr_data | input | 16 | Write data; the divisor uses the low 8 bits and the mode uses the low 6 bits |
| ext_sck | input | 1 | External bit clock, used in slave mode |
| ext_ws | input | 1 | External word strobe, used in slave mode |
| sck_o | output | 1 | Bit clock output, driven in master mode |
| ws_o | output | 1 | Word strobe output, driven in master mode when enabled |
| sd_o | output | 1 | Serial data, MSB first |
| irq_o | output | 1 | One-cycle sample interrupt pulse |
| status_o | output | 2 | Bit 0 strobe level, bit 1 left channel |

## Verification
The bench builds the block with the default parameters: 16-bit words, an 8-bit divisor, and a reset divisor of 8. At run time it programs the divisor to 0, 2 and 5. Divisor 0 covers the fastest bit clock, where the bit clock toggles every cycle. Divisor 2 keeps frames at 192 cycles, so exact falling-edge times, the repetition of data across frames and every interrupt mode can be counted over whole frames. Divisor 5 is used for a rewrite in the middle of a frame, to show the restart. Slave mode is driven by an external clock with a half period of six cycles, so the synchronizer delay fits inside each bit.

// File: rtl/i2s_tmg_pkg.sv
package i2s_tmg_pkg;

    typedef enum logic [1:0] {
        SEL_LEFT  = 2'd0,
        SEL_RIGHT = 2'd1,
        SEL_DIV   = 2'd2,
        SEL_MODE  = 2'd3
    } reg_sel_e;

    localparam int MODE_W      = 6;
    localparam int MB_MASTER   = 0;
    localparam int MB_WS_EN    = 2;
    localparam int MB_IRQ_RISE = 3;
    localparam int MB_IRQ_FALL = 4;
    localparam int MB_IRQ_WORD = 5;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } slot_st_e;

endpackage

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sck_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             sck_q;
    logic             at_end;

    assign at_end = (cnt_q == div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck_q <= 1'b1;
        end else if (restart_i) begin
            cnt_q <= '0;
            sck_q <= 1'b1;
        end else if (run_i) begin
            if (at_end) begin
                cnt_q <= '0;
                sck_q <= ~sck_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sck_o  = sck_q;
    assign fall_o = run_i & ~restart_i & sck_q & at_end;

    // R2: the half-period counter never runs past the programmed divisor
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div_i);

endmodule

// File: rtl/i2s_ext_sync.sv
module i2s_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sck_i,
    input  logic ext_ws_i,
    output logic fall_o,
    output logic ws_o
);
    logic [2:0] sck_sh;
    logic [1:0] ws_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sh <= '0;
            ws_sh  <= '0;
        end else begin
            sck_sh <= {sck_sh[1:0], ext_sck_i};
            ws_sh  <= {ws_sh[0], ext_ws_i};
        end
    end

    assign fall_o = sck_sh[2] & ~sck_sh[1];
    assign ws_o   = ws_sh[1];

endmodule

// File: rtl/i2s_frame_fsm.sv
module i2s_frame_fsm
    import i2s_tmg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          master_i,
    input  logic          fall_i,
    input  logic          ext_ws_i,
    input  logic [DW-1:0] left_i,
    input  logic [DW-1:0] right_i,
    output logic          ws_o,
    output logic          sd_o,
    output logic          ws_rise_o,
    output logic          ws_fall_o,
    output logic          word_start_o
);
    localparam int CW   = $clog2(2 * DW);
    localparam int LAST = 2 * DW - 1;

    slot_st_e      state_q, state_d;
    logic [CW-1:0] pos_q, pos_nxt;
    logic          ws_q, ws_new, change;
    logic          load_en, shift_en;
    logic [DW-1:0] sh_q;

    assign pos_nxt = (pos_q == CW'(LAST)) ? '0 : pos_q + 1'b1;
    assign ws_new  = master_i ? (pos_q >= CW'(DW)) : ext_ws_i;
    assign change  = fall_i & (ws_new != ws_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         state_q <= ST_SYNC;
        else if (restart_i) state_q <= ST_SYNC;
        else                state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC:  if (change) state_d = ST_ARMED;
            ST_ARMED: if (fall_i) state_d = change ? ST_ARMED : ST_SHIFT;
            ST_SHIFT: if (change) state_d = ST_ARMED;
            default:  state_d = ST_SYNC;
        endcase
    end

    // outputs of the controller
    always_comb begin
        load_en = 1'b0;
        unique case (state_q)
            ST_SYNC:  load_en = 1'b0;
            ST_ARMED: load_en = fall_i & ~change;
            ST_SHIFT: load_en = 1'b0;
            default:  load_en = 1'b0;
        endcase
        shift_en = fall_i & ~load_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            ws_q  <= 1'b1;
            sh_q  <= '0;
        end else if (restart_i) begin
            pos_q <= '0;
            ws_q  <= 1'b1;
            sh_q  <= '0;
        end else begin
            if (fall_i) pos_q <= pos_nxt;
            if (change) ws_q  <= ws_new;
            if (load_en)       sh_q <= ws_q ? right_i : left_i;
            else if (shift_en) sh_q <= {sh_q[DW-2:0], 1'b0};
        end
    end

    assign ws_o         = ws_q;
    assign sd_o         = sh_q[DW-1];
    assign ws_rise_o    = change & ws_new;
    assign ws_fall_o    = change & ~ws_new;
    assign word_start_o = load_en;

    // R4: the strobe moves only on a bit-clock falling edge or a restart
    p_ws_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws_q) |-> $past(fall_i || restart_i));

    // R4: a slot is armed only after a strobe change or while still armed
    p_armed_after_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> $past(change || state_q == ST_ARMED));

    // R6: the data line is silent until the first slot is loaded
    p_sync_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC) |-> !sd_o);

endmodule

// File: rtl/i2s_tmg_top.sv
module i2s_tmg_top
    import i2s_tmg_pkg::*;
#(
    parameter int DW      = 16,
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          ext_sck,
    input  logic          ext_ws,
    output logic          sck_o,
    output logic          ws_o,
    output logic          sd_o,
    output logic          irq_o,
    output logic [1:0]    status_o
);
    logic [DW-1:0]     left_q, right_q;
    logic [DIV_W-1:0]  div_q;
    logic [MODE_W-1:0] mode_q;
    logic              irq_q;
    logic              restart, master;
    logic              gen_sck, gen_fall, ext_fall, ext_ws_s, fall;
    logic              ws_int, ws_rise, ws_fall, word_start;
    reg_sel_e          sel;

    assign sel     = reg_sel_e'(wr_sel);
    assign restart = wr_en & ((sel == SEL_DIV) | (sel == SEL_MODE));
    assign master  = mode_q[MB_MASTER];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
            div_q   <= DIV_W'(DIV_RST);
            mode_q  <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_LEFT:  left_q  <= wr_data;
                SEL_RIGHT: right_q <= wr_data;
                SEL_DIV:   div_q   <= wr_data[DIV_W-1:0];
                SEL_MODE:  mode_q  <= wr_data[MODE_W-1:0];
                default:   ;
            endcase
        end
    end

    i2s_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .run_i     (master),
        .div_i     (div_q),
        .sck_o     (gen_sck),
        .fall_o    (gen_fall)
    );

    i2s_ext_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sck_i (ext_sck),
        .ext_ws_i  (ext_ws),
        .fall_o    (ext_fall),
        .ws_o      (ext_ws_s)
    );

    assign fall = master ? gen_fall : (ext_fall & ~restart);

    i2s_frame_fsm #(.DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (restart),
        .master_i     (master),
        .fall_i       (fall),
        .ext_ws_i     (ext_ws_s),
        .left_i       (left_q),
        .right_i      (right_q),
        .ws_o         (ws_int),
        .sd_o         (sd_o),
        .ws_rise_o    (ws_rise),
        .ws_fall_o    (ws_fall),
        .word_start_o (word_start)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (ws_rise    & mode_q[MB_IRQ_RISE])
                           | (ws_fall    & mode_q[MB_IRQ_FALL])
                           | (word_start & mode_q[MB_IRQ_WORD]);
    end

    assign irq_o    = irq_q;
    assign sck_o    = master & gen_sck;
    assign ws_o     = master & mode_q[MB_WS_EN] & ws_int;
    assign status_o = {~ws_int, ws_int};

    // R4: in master mode the strobe pin moves together with a bit-clock fall
    p_ws_with_sck_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !$stable(ws_o) && !$past(restart)) |-> $fell(sck_o));

    // R8: no interrupt pulse without an interrupt source selected
    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(mode_q[MB_IRQ_WORD:MB_IRQ_RISE] != '0));

endmodule

// File: tb/i2s_tmg_top_tb.sv
module i2s_tmg_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        ext_sck = 1'b1;
    logic        ext_ws = 1'b1;
    logic        sck_o, ws_o, sd_o, irq_o;
    logic [1:0]  status_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int fall_cnt = 0;
    int irq_cnt = 0;
    int irq_hi = 0;
    logic prev_sck = 1'b0;
    logic f_sd [256];
    logic f_ws [256];
    int   f_t  [256];

    always #4 clk = ~clk;

    i2s_tmg_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ext_sck(ext_sck), .ext_ws(ext_ws),
        .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o), .irq_o(irq_o),
        .status_o(status_o)
    );

    // monitor: samples outputs at the falling system clock edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_sck && !sck_o) begin
            fall_cnt = fall_cnt + 1;
            f_sd[fall_cnt & 255] = sd_o;
            f_ws[fall_cnt & 255] = ws_o;
            f_t[fall_cnt & 255]  = cyc;
        end
        prev_sck = sck_o;
        if (irq_o) begin
            irq_cnt = irq_cnt + 1;
            if (status_o[0]) irq_hi = irq_hi + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_falls(input int n);
        while (fall_cnt < n) begin
            @(negedge clk); #1;
        end
    endtask

    function automatic logic [15:0] word_at(input int first);
        logic [15:0] w = '0;
        for (int i = 0; i < 16; i++) w = {w[14:0], f_sd[(first + i) & 255]};
        return w;
    endfunction

    task automatic t_reset;
        chk(sck_o == 0 && ws_o == 0 && sd_o == 0 && irq_o == 0, "R1 outputs", {sck_o, ws_o, sd_o, irq_o}, 0);
        chk(status_o == 2'b01, "R1 status", status_o, 2'b01);
    endtask

    task automatic t_master(input int div, input logic [15:0] lw, input logic [15:0] rw);
        int t0, b;
        write_reg(2'd0, lw);
        write_reg(2'd1, rw);
        write_reg(2'd2, 16'(div));
        write_reg(2'd3, 16'h0005);
        t0 = cyc; b = fall_cnt;
        wait_falls(b + 1);
        chk(f_t[(b + 1) & 255] - t0 == div + 1, "R2 first fall", f_t[(b + 1) & 255] - t0, div + 1);
        wait_falls(b + 17);
        chk(status_o == 2'b01, "R12 right status", status_o, 2'b01);
        wait_falls(b + 33);
        chk(status_o == 2'b10, "R12 left status", status_o, 2'b10);
        chk(f_t[(b + 2) & 255] - f_t[(b + 1) & 255] == 2 * (div + 1), "R2 bit period",
            f_t[(b + 2) & 255] - f_t[(b + 1) & 255], 2 * (div + 1));
        chk(f_t[(b + 33) & 255] - f_t[(b + 1) & 255] == 64 * (div + 1), "R3 frame length",
            f_t[(b + 33) & 255] - f_t[(b + 1) & 255], 64 * (div + 1));
        chk({f_ws[(b + 1) & 255], f_ws[(b + 16) & 255], f_ws[(b + 17) & 255], f_ws[(b + 32) & 255], f_ws[(b + 33) & 255]} == 5'b00110,
            "R4 strobe pattern",
            {f_ws[(b + 1) & 255], f_ws[(b + 16) & 255], f_ws[(b + 17) & 255], f_ws[(b + 32) & 255], f_ws[(b + 33) & 255]}, 5'b00110);
        chk(word_at(b + 2) == lw, "R4 left word", word_at(b + 2), lw);
        chk(word_at(b + 18) == rw, "R4 right word", word_at(b + 18), rw);
    endtask

    task automatic t_repeat(input logic [15:0] lw, input logic [15:0] rw_new);
        int b;
        b = fall_cnt;
        wait_falls(b + 3);
        write_reg(2'd1, rw_new);
        wait_falls(b + 32);
        chk(word_at(b + 1) == lw, "R5 left repeated", word_at(b + 1), lw);
        chk(word_at(b + 17) == rw_new, "R5 new right word", word_at(b + 17), rw_new);
    endtask

    task automatic t_resync(input logic [15:0] lw);
        int t0, b;
        wait_falls(fall_cnt + 10);
        write_reg(2'd2, 16'd5);
        chk(sck_o == 1 && ws_o == 1 && sd_o == 0 && status_o == 2'b01, "R6 restart state",
            {sck_o, ws_o, sd_o, status_o}, 5'b11001);
        t0 = cyc; b = fall_cnt;
        wait_falls(b + 17);
        chk(f_t[(b + 1) & 255] - t0 == 6, "R6 first fall after rewrite", f_t[(b + 1) & 255] - t0, 6);
        chk(f_ws[(b + 1) & 255] == 0 && word_at(b + 2) == lw, "R6 left word after restart", word_at(b + 2), lw);
    endtask

    task automatic t_wsen(input logic [15:0] lw);
        int b;
        bit any_hi = 0;
        write_reg(2'd2, 16'd2);
        write_reg(2'd3, 16'h0001);
        b = fall_cnt;
        wait_falls(b + 20);
        chk(status_o == 2'b01, "R7 status tracks strobe", status_o, 2'b01);
        wait_falls(b + 33);
        for (int i = 1; i <= 33; i++) if (f_ws[(b + i) & 255]) any_hi = 1;
        chk(!any_hi, "R7 ws_o held low", any_hi, 0);
        chk(word_at(b + 2) == lw, "R7 data unaffected", word_at(b + 2), lw);
    endtask

    task automatic t_irq(input logic [15:0] mode, input int exp_cnt, input int exp_hi, input string tag);
        int c0, h0;
        write_reg(2'd2, 16'd2);
        write_reg(2'd3, mode);
        c0 = irq_cnt; h0 = irq_hi;
        repeat (384) @(negedge clk);
        #1;
        chk(irq_cnt - c0 == exp_cnt, {tag, " count"}, irq_cnt - c0, exp_cnt);
        chk(irq_hi - h0 == exp_hi, {tag, " strobe level"}, irq_hi - h0, exp_hi);
    endtask

    task automatic t_slave(input logic [15:0] lw, input logic [15:0] rw);
        logic s_sd [66];
        logic [15:0] l1 = '0, r1 = '0, l2 = '0, r2 = '0;
        bit quiet = 1;
        bit st_ok = 1;
        int c0;
        write_reg(2'd3, 16'h0024);
        c0 = irq_cnt;
        for (int n = 1; n <= 65; n++) begin
            ext_sck = 1'b0;
            ext_ws  = (((n - 1) % 32) >= 16);
            repeat (6) @(negedge clk);
            #1;
            s_sd[n] = sd_o;
            if (sck_o || ws_o) quiet = 0;
            if (status_o[0] != ext_ws) st_ok = 0;
            ext_sck = 1'b1;
            repeat (6) @(negedge clk);
            #1;
            if (sck_o || ws_o) quiet = 0;
        end
        for (int i = 0; i < 16; i++) begin
            l1 = {l1[14:0], s_sd[2 + i]};
            r1 = {r1[14:0], s_sd[18 + i]};
            l2 = {l2[14:0], s_sd[34 + i]};
            r2 = {r2[14:0], s_sd[50 + i]};
        end
        chk(quiet, "R11 sck_o/ws_o low in slave", quiet, 1);
        chk(l1 == lw && l2 == lw, "R11 slave left word", l2, lw);
        chk(r1 == rw && r2 == rw, "R11 slave right word", r2, rw);
        chk(st_ok, "R12 status follows external strobe", st_ok, 1);
        chk(irq_cnt - c0 == 4, "R10 slave word interrupts", irq_cnt - c0, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_master(2, 16'hA5C3, 16'h3C96);
        t_repeat(16'hA5C3, 16'h5E1F);
        t_resync(16'hA5C3);
        t_master(0, 16'h8001, 16'h7FFE);
        t_wsen(16'h8001);
        t_irq(16'h0009, 2, 2, "R8 rising");
        t_irq(16'h0011, 2, 0, "R9 falling");
        t_irq(16'h0021, 4, 2, "R10 word start");
        t_irq(16'h0039, 8, 4, "R10 all sources");
        t_irq(16'h0001, 0, 0, "R8 none enabled");
        t_slave(16'h8001, 16'h7FFE);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule